// File: doc/BRIEF.md
# Noise-Adaptive Detection Threshold Controller

This block derives the amplitude threshold that a leading-edge first-path detector uses to accept a channel sample as the direct path. It watches a per-ranging-cycle strobe together with two 12-bit amplitude measurements, the noise floor and the first-path magnitude. It recomputes the threshold only once per adaptation period. Between updates the published threshold is held, so the detector sees a stable value for a whole period.

There are two rules. In the fixed rule the threshold is twice the noise floor, with a minimum value. In the adaptive rule the ratio of first-path magnitude to noise floor is placed in one of three bands. Integer comparisons decide the band, so no logarithm is needed. Each band picks a noise multiplier of 1.5, 2 or 4, and the result is clamped to a fixed window. The threshold is registered, and a one-cycle valid pulse marks each new value.

Top module: `adaptive_threshold_ctl`

## Requirements
- R1: With `modeAdaptive` = 0, an update loads `threshold` = max(2 × noiseFloor, 0x0080).
- R2: With `modeAdaptive` = 1 and firstPathMag < 2 × noiseFloor, the unclamped value is noiseFloor + floor(noiseFloor / 2).
- R3: With `modeAdaptive` = 1, the unclamped value is 4 × noiseFloor when firstPathMag × 1000 > noiseFloor × 5623 and 2 × noiseFloor when neither band condition holds. Equality on either boundary counts as the middle band.
- R4: In adaptive mode the loaded value is clamped to the range 0x0040 to 0x0400 inclusive. A zero noise floor therefore yields 0x0040.
- R5: Only every tenth `cycleStrobe` pulse causes an update. The inputs and the mode are sampled at the clock edge where that tenth strobe is high. `threshold` takes the new value and `thresholdValid` is high for exactly one cycle after that edge.
- R6: Between updates, `threshold` holds its value and `thresholdValid` stays low. Strobes other than the tenth, and input changes, have no effect on either output.
- R7: Reset (active-low `rstN`) clears the strobe count, sets `threshold` to 0x0200 and drives `thresholdValid` low. Strobes seen before the reset do not count toward the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleStrobe | input | 1 | One pulse per ranging cycle |
| modeAdaptive | input | 1 | 1 = banded adaptive rule, 0 = fixed rule |
| noiseFloor | input | 12 | Measured noise floor amplitude |
| firstPathMag | input | 12 | Measured first-path amplitude |
| threshold | output | 16 | Current detection threshold |
| thresholdValid | output | 1 | One-cycle pulse when a new threshold is loaded |

## Verification
The bench builds the block with its default parameters: a period of ten strobes, 12-bit amplitudes, a 16-bit threshold, and the 1000/5623 ratio for the upper band. These defaults let the bench drive noise floors that sit exactly where each rule switches. It covers 2 × noise equal to the fixed minimum and 4 × noise landing exactly on the upper clamp. It also covers first-path magnitudes one step either side of the upper-band ratio, 2 × noise equal to the first-path magnitude, and odd noise floors that show the truncation of the 1.5 multiplier. A full period spans only ten strobes, so a reset in the middle of a count can be followed by exactly enough strobes to show that the pre-reset strobes are forgotten.

// File: rtl/athr_pkg.sv
package athr_pkg;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2
  } snrBand_e;

  typedef struct packed {
    logic load;
    logic useAdaptive;
  } athrCtl_t;

endpackage

// File: rtl/athr_ctrl.sv
module athr_ctrl
  import athr_pkg::*;
#(
  parameter int PERIOD = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cycleStrobe,
  input  logic     modeAdaptive,
  output athrCtl_t ctlStb
);

  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] strobeCnt;
  logic             atLast;

  assign atLast = (strobeCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeCnt <= '0;
    end else if (cycleStrobe) begin
      if (atLast) strobeCnt <= '0;
      else        strobeCnt <= strobeCnt + 1'b1;
    end
  end

  always_comb begin
    ctlStb.load        = cycleStrobe && atLast;
    ctlStb.useAdaptive = modeAdaptive;
  end

endmodule

// File: rtl/athr_datapath.sv
module athr_datapath
  import athr_pkg::*;
#(
  parameter int NOISE_W      = 12,
  parameter int THRESH_W     = 16,
  parameter int STATIC_MIN   = 16'h0080,
  parameter int CLAMP_LO     = 16'h0040,
  parameter int CLAMP_HI     = 16'h0400,
  parameter int RESET_THRESH = 16'h0200,
  parameter int HIGH_NUM     = 5623,
  parameter int HIGH_DEN     = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  athrCtl_t            ctlStb,
  input  logic [NOISE_W-1:0]  noiseFloor,
  input  logic [NOISE_W-1:0]  firstPathMag,
  output logic [THRESH_W-1:0] threshold,
  output logic                thresholdValid
);

  localparam int PROD_W = NOISE_W + 16;

  logic [THRESH_W-1:0] noiseW, fpW, twoN, fourN, halfUpN;
  logic [THRESH_W-1:0] staticVal, bandVal, adaptVal, nextVal;
  logic [PROD_W-1:0]   fpScaled, noiseScaled;
  snrBand_e            band;

  always_comb begin
    noiseW  = THRESH_W'(noiseFloor);
    fpW     = THRESH_W'(firstPathMag);
    twoN    = noiseW << 1;
    fourN   = noiseW << 2;
    halfUpN = noiseW + (noiseW >> 1);

    fpScaled    = PROD_W'(firstPathMag) * PROD_W'(HIGH_DEN);
    noiseScaled = PROD_W'(noiseFloor) * PROD_W'(HIGH_NUM);

    if (fpW < twoN)                  band = BAND_LOW;
    else if (fpScaled > noiseScaled) band = BAND_HIGH;
    else                             band = BAND_MID;

    case (band)
      BAND_LOW:  bandVal = halfUpN;
      BAND_HIGH: bandVal = fourN;
      default:   bandVal = twoN;
    endcase

    if (bandVal < THRESH_W'(CLAMP_LO))      adaptVal = THRESH_W'(CLAMP_LO);
    else if (bandVal > THRESH_W'(CLAMP_HI)) adaptVal = THRESH_W'(CLAMP_HI);
    else                                    adaptVal = bandVal;

    staticVal = (twoN > THRESH_W'(STATIC_MIN)) ? twoN : THRESH_W'(STATIC_MIN);
    nextVal   = ctlStb.useAdaptive ? adaptVal : staticVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      threshold      <= THRESH_W'(RESET_THRESH);
      thresholdValid <= 1'b0;
    end else begin
      thresholdValid <= ctlStb.load;
      if (ctlStb.load) threshold <= nextVal;
    end
  end

endmodule

// File: rtl/adaptive_threshold_ctl.sv
module adaptive_threshold_ctl
  import athr_pkg::*;
#(
  parameter int PERIOD       = 10,
  parameter int NOISE_W      = 12,
  parameter int THRESH_W     = 16,
  parameter int STATIC_MIN   = 16'h0080,
  parameter int CLAMP_LO     = 16'h0040,
  parameter int CLAMP_HI     = 16'h0400,
  parameter int RESET_THRESH = 16'h0200,
  parameter int HIGH_NUM     = 5623,
  parameter int HIGH_DEN     = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cycleStrobe,
  input  logic                modeAdaptive,
  input  logic [NOISE_W-1:0]  noiseFloor,
  input  logic [NOISE_W-1:0]  firstPathMag,
  output logic [THRESH_W-1:0] threshold,
  output logic                thresholdValid
);

  athrCtl_t ctlStb;

  athr_ctrl #(.PERIOD(PERIOD)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cycleStrobe  (cycleStrobe),
    .modeAdaptive (modeAdaptive),
    .ctlStb       (ctlStb)
  );

  athr_datapath #(
    .NOISE_W      (NOISE_W),
    .THRESH_W     (THRESH_W),
    .STATIC_MIN   (STATIC_MIN),
    .CLAMP_LO     (CLAMP_LO),
    .CLAMP_HI     (CLAMP_HI),
    .RESET_THRESH (RESET_THRESH),
    .HIGH_NUM     (HIGH_NUM),
    .HIGH_DEN     (HIGH_DEN)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .ctlStb         (ctlStb),
    .noiseFloor     (noiseFloor),
    .firstPathMag   (firstPathMag),
    .threshold      (threshold),
    .thresholdValid (thresholdValid)
  );

endmodule

// File: rtl/athr_chk.sv
module athr_chk #(
  parameter int PERIOD     = 10,
  parameter int NOISE_W    = 12,
  parameter int THRESH_W   = 16,
  parameter int STATIC_MIN = 16'h0080,
  parameter int CLAMP_LO   = 16'h0040,
  parameter int CLAMP_HI   = 16'h0400
) (
  input logic                clk,
  input logic                rstN,
  input logic                cycleStrobe,
  input logic                modeAdaptive,
  input logic [NOISE_W-1:0]  noiseFloor,
  input logic [NOISE_W-1:0]  firstPathMag,
  input logic [THRESH_W-1:0] threshold,
  input logic                thresholdValid
);

  int seenStrobes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenStrobes <= 0;
    else if (cycleStrobe) seenStrobes <= (seenStrobes == PERIOD - 1) ? 0 : seenStrobes + 1;
  end

  // R5: valid is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    thresholdValid |=> !thresholdValid);

  // R5: valid only follows the tenth strobe of a period
  a_r5_cadence: assert property (@(posedge clk) disable iff (!rstN)
    thresholdValid |-> ($past(cycleStrobe) && ($past(seenStrobes) == PERIOD - 1)));

  // R6: threshold holds when no update is reported
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !thresholdValid |-> $stable(threshold));

  // R4: adaptive results stay inside the clamp window
  a_r4_clamp_window: assert property (@(posedge clk) disable iff (!rstN)
    (thresholdValid && $past(modeAdaptive)) |->
      (threshold >= THRESH_W'(CLAMP_LO) && threshold <= THRESH_W'(CLAMP_HI)));

  // R1: fixed-rule results never fall below the minimum
  a_r1_static_floor: assert property (@(posedge clk) disable iff (!rstN)
    (thresholdValid && !$past(modeAdaptive)) |-> (threshold >= THRESH_W'(STATIC_MIN)));

endmodule

bind adaptive_threshold_ctl athr_chk #(
  .PERIOD     (PERIOD),
  .NOISE_W    (NOISE_W),
  .THRESH_W   (THRESH_W),
  .STATIC_MIN (STATIC_MIN),
  .CLAMP_LO   (CLAMP_LO),
  .CLAMP_HI   (CLAMP_HI)
) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .cycleStrobe    (cycleStrobe),
  .modeAdaptive   (modeAdaptive),
  .noiseFloor     (noiseFloor),
  .firstPathMag   (firstPathMag),
  .threshold      (threshold),
  .thresholdValid (thresholdValid)
);

// File: tb/adaptive_threshold_ctl_tb_top.sv
module adaptive_threshold_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleStrobe = 1'b0;
  logic        modeAdaptive = 1'b0;
  logic [11:0] noiseFloor = '0;
  logic [11:0] firstPathMag = '0;
  logic [15:0] threshold;
  logic        thresholdValid;

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    finished = 0;
  logic [15:0] expQ[$];
  string tagQ[$];
  logic [15:0] lastExp = 16'h0200;

  always #4 clk = ~clk;

  adaptive_threshold_ctl dut_i (
    .clk(clk), .rstN(rstN), .cycleStrobe(cycleStrobe), .modeAdaptive(modeAdaptive),
    .noiseFloor(noiseFloor), .firstPathMag(firstPathMag),
    .threshold(threshold), .thresholdValid(thresholdValid)
  );

  function automatic logic [15:0] modelThr(int n, int fp, bit adaptive);
    int v;
    if (!adaptive) return 16'((2 * n > 128) ? 2 * n : 128);
    if (fp < 2 * n)               v = n + n / 2;
    else if (fp * 1000 > n * 5623) v = 4 * n;
    else                          v = 2 * n;
    if (v < 64)   v = 64;
    if (v > 1024) v = 1024;
    return 16'(v);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare every valid pulse against the scoreboard
  always @(negedge clk) begin
    if (rstN && thresholdValid) begin
      if (expQ.size() == 0) begin
        check("R5 unexpected update", thresholdValid, 1'b0);
      end else begin
        string t;
        logic [15:0] e;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, threshold, e);
      end
    end
  end

  task automatic strobeOnce(int n, int fp, bit adaptive);
    @(negedge clk);
    noiseFloor = 12'(n); firstPathMag = 12'(fp); modeAdaptive = adaptive;
    cycleStrobe = 1'b1;
    @(negedge clk);
    cycleStrobe = 1'b0;
    noiseFloor = 12'hABC; firstPathMag = 12'h123; modeAdaptive = ~adaptive;
  endtask

  // Driver: nine filler strobes, hold check, then the counted strobe
  task automatic runPeriod(string tag, int n, int fp, bit adaptive);
    for (int i = 0; i < 9; i++) strobeOnce(4095 - i, i, ~adaptive);
    @(negedge clk);
    check("R6 hold after filler strobes", threshold, lastExp);
    lastExp = modelThr(n, fp, adaptive);
    expQ.push_back(lastExp);
    tagQ.push_back(tag);
    strobeOnce(n, fp, adaptive);
    @(negedge clk);
    check("R6 valid low after pulse", {15'd0, thresholdValid}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset threshold", threshold, 16'h0200);
    check("R7 reset valid", {15'd0, thresholdValid}, 16'd0);
    rstN = 1'b1;

    runPeriod("R1 zero noise static", 0, 0, 1'b0);
    runPeriod("R1 2n equals minimum", 12'h040, 5, 1'b0);
    runPeriod("R1 just above minimum", 12'h041, 5, 1'b0);
    runPeriod("R1 max noise static", 12'hFFF, 0, 1'b0);
    runPeriod("R2 low band even", 12'h100, 12'h1FF, 1'b1);
    runPeriod("R2 low band odd truncation", 12'h101, 1, 1'b1);
    runPeriod("R3 fp equals 2n is middle", 12'h100, 12'h200, 1'b1);
    runPeriod("R3 one below high ratio", 12'h100, 1439, 1'b1);
    runPeriod("R3 high band at upper clamp", 12'h100, 1440, 1'b1);
    runPeriod("R4 high band clamped", 12'h200, 12'hFFF, 1'b1);
    runPeriod("R4 middle band clamped", 12'h300, 12'h600, 1'b1);
    runPeriod("R4 low band lower clamp", 12'h020, 12'h010, 1'b1);
    runPeriod("R4 zero noise adaptive", 0, 0, 1'b1);
    runPeriod("R4 zero noise high band", 0, 5, 1'b1);

    // R7: reset mid-count discards earlier strobes
    for (int i = 0; i < 5; i++) strobeOnce(100, 100, 1'b0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R7 threshold after mid reset", threshold, 16'h0200);
    rstN = 1'b1;
    lastExp = 16'h0200;
    for (int i = 0; i < 5; i++) strobeOnce(100, 100, 1'b0);
    @(negedge clk);
    check("R7 no update from pre-reset strobes", threshold, 16'h0200);
    for (int i = 0; i < 4; i++) strobeOnce(100, 100, 1'b0);
    lastExp = modelThr(12'h050, 0, 1'b0);
    expQ.push_back(lastExp);
    tagQ.push_back("R5 tenth strobe after reset");
    strobeOnce(12'h050, 0, 1'b0);
    repeat (2) @(negedge clk);
    check("R5 scoreboard drained", 16'(expQ.size()), 16'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule